// File: doc/BRIEF.md
# Programmable Serial Transceiver

This block is a full-duplex asynchronous serial port attached to a small CPU bus. Software writes a frame setting (character length, parity on or off, parity sense, stop length) and a baud divisor. It then writes characters into a one-deep transmit holding register and reads received characters from a one-deep receive buffer. A status byte reports whether the holding register can take another character, whether a received character is waiting, and whether the last character had a parity error, a framing error, or arrived on top of an unread one.

A shared baud divider produces one tick every `div` clocks. Both directions run on 16 ticks per bit. The transmitter sequencer has the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP. TX_IDLE goes to TX_START on a tick when a character is held. TX_START goes to TX_DATA after 16 ticks. TX_DATA goes to TX_PARITY, or to TX_STOP when parity is off, after the last data bit. TX_PARITY goes to TX_STOP after 16 ticks. At the end of the stop time (16, 24 or 32 ticks), TX_STOP goes straight to TX_START if another character is held, and to TX_IDLE otherwise.

The receiver has the states RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP. RX_IDLE goes to RX_START when a tick sees the line low. RX_START goes to RX_DATA if the line is still low 8 ticks later, and back to RX_IDLE if it is not. RX_DATA samples each bit 16 ticks after the previous sample point, then goes to RX_PARITY or RX_STOP. RX_PARITY goes to RX_STOP after one sample. RX_STOP samples the first stop bit, delivers the character and returns to RX_IDLE.

Bus map: address 0 reads the receive buffer and writes the holding register. Address 1 reads status and writes the frame setting. Address 2 reads and writes the divisor. Address 3 reads as zero.

Frame setting byte: bits [1:0] give the length as 5 plus the field value. Bit 2 enables parity. Bit 3 selects odd parity (0 selects even). Bits [5:4] select the stop length: 0 is one bit, 1 is one and a half bits, 2 or 3 is two bits. Status byte: bit 0 is holding-empty, bit 1 is receive-ready, bit 2 is parity error, bit 3 is framing error, bit 4 is overrun, and bits 7:5 are zero.

Top module: `serial_xcvr`

## Requirements
- R1: After reset the status byte reads 0x01, the serial output is high, and the divisor reads DIV_RESET.
- R2: A transmitted character is a low start bit, then the configured number of data bits starting with bit 0, then the stop time held high. Each bit lasts 16·div clocks. Written bits above the configured length are not sent, and the line is high whenever the transmitter is idle.
- R3: With parity enabled, one parity bit follows the data. It makes the count of ones in data plus parity even when bit 3 is 0, and odd when bit 3 is 1. With parity disabled, no parity bit is sent.
- R4: The stop time lasts 16, 24 or 32 ticks for stop settings 0, 1 and 2. With a character already waiting, the next start bit begins exactly at the end of the stop time, so start-to-start spacing is (1+len+parity)·16·div + stop_ticks·div clocks.
- R5: A write to address 0 clears holding-empty (status bit 0). The bit is set again once the transmitter takes the character.
- R6: A received character is presented right-aligned, with the unused upper bits zero, and receive-ready (status bit 1) is set.
- R7: A read of address 0 clears receive-ready, parity error, framing error and overrun.
- R8: A received parity bit that does not match the configured sense sets parity error (status bit 2).
- R9: A first stop bit sampled low sets framing error (status bit 3).
- R10: A character that completes while receive-ready is still set sets overrun (status bit 4) and replaces the buffered character.
- R11: A low pulse shorter than half a bit time does not start a character.
- R12: The divisor register sets the tick period. After a tick, no further tick follows for div clocks whenever div > 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Bus access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The transmitter is driven with four framings: 8 bits without parity, 5 bits even, 7 bits odd, and 6 bits with a written value whose seventh bit is zero. Sampling every bit centre separates bit-order, parity-sense and truncation faults. Back-to-back pairs of all-zero characters under each stop setting make the start-to-start spacing expose a wrong stop count or a lost cycle between frames. The receiver is fed a clean character, a short character with good parity, a flipped parity bit, a low stop bit, two unread characters in a row and a short glitch. Each of these distinguishes one status flag, or the start check, from the others.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int OVS = 16;
    localparam logic [4:0] BIT_LAST = 5'(OVS - 1);
    localparam logic [4:0] MID_LAST = 5'(OVS / 2 - 1);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
    } rx_state_e;

    function automatic logic [4:0] stop_last(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'(OVS - 1);
            2'd1:    return 5'(OVS + OVS / 2 - 1);
            default: return 5'(2 * OVS - 1);
        endcase
    endfunction

    function automatic logic [7:0] len_mask(input logic [1:0] sel);
        return 8'hFF >> (2'd3 - sel);
    endfunction

endpackage

// File: rtl/xcvr_baud.sv
module xcvr_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= (div == '0) ? '0 : div - DIV_W'(1);
        else
            cnt <= cnt - DIV_W'(1);
    end
endmodule

// File: rtl/xcvr_tx.sv
module xcvr_tx
    import xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic [1:0] stop_sel,
    input  logic       thr_full,
    input  logic [7:0] thr_data,
    output logic       take,
    output logic       txd,
    output logic       idle
);
    tx_state_e  state, nxt;
    logic [4:0] cnt;
    logic [7:0] shreg;
    logic [2:0] bitidx;
    logic       par_bit;
    logic [2:0] bit_last;
    logic [4:0] stop_end;
    logic       bit_end;

    assign bit_last = 3'd4 + {1'b0, len_sel};
    assign stop_end = stop_last(stop_sel);
    assign bit_end  = tick && (cnt == BIT_LAST);
    assign take     = tick && thr_full &&
                      ((state == TX_IDLE) || (state == TX_STOP && cnt == stop_end));

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (tick && thr_full) nxt = TX_START;
            TX_START:  if (bit_end) nxt = TX_DATA;
            TX_DATA:   if (bit_end && bitidx == bit_last) nxt = par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) nxt = TX_STOP;
            TX_STOP:   if (tick && cnt == stop_end) nxt = thr_full ? TX_START : TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            bitidx  <= '0;
            par_bit <= 1'b0;
        end else begin
            if (tick) begin
                if (nxt != state || (state != TX_STOP && cnt == BIT_LAST))
                    cnt <= '0;
                else
                    cnt <= cnt + 5'd1;
            end
            if (take) begin
                shreg   <= thr_data;
                bitidx  <= '0;
                par_bit <= (^(thr_data & len_mask(len_sel))) ^ par_odd;
            end else if (state == TX_DATA && bit_end) begin
                shreg  <= shreg >> 1;
                bitidx <= bitidx + 3'd1;
            end
        end
    end

    always_comb begin
        idle = (state == TX_IDLE);
        unique case (state)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/xcvr_rx.sv
module xcvr_rx
    import xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxs,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    rx_state_e  state, nxt;
    logic [4:0] cnt;
    logic [7:0] shreg;
    logic [2:0] bitidx;
    logic       par_acc;
    logic       perr_q;
    logic [2:0] bit_last;
    logic       bit_end;
    logic       mid_hit;

    assign bit_last = 3'd4 + {1'b0, len_sel};
    assign bit_end  = tick && (cnt == BIT_LAST);
    assign mid_hit  = tick && (cnt == MID_LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (tick && !rxs) nxt = RX_START;
            RX_START:  if (mid_hit) nxt = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_end && bitidx == bit_last) nxt = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_end) nxt = RX_STOP;
            RX_STOP:   if (bit_end) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            bitidx  <= '0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
            done    <= 1'b0;
            data    <= '0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (nxt != state || cnt == BIT_LAST)
                    cnt <= '0;
                else
                    cnt <= cnt + 5'd1;
            end
            unique case (state)
                RX_START: if (mid_hit) begin
                    shreg   <= '0;
                    bitidx  <= '0;
                    par_acc <= 1'b0;
                    perr_q  <= 1'b0;
                end
                RX_DATA: if (bit_end) begin
                    shreg   <= {rxs, shreg[7:1]};
                    bitidx  <= bitidx + 3'd1;
                    par_acc <= par_acc ^ rxs;
                end
                RX_PARITY: if (bit_end) perr_q <= ((par_acc ^ rxs) != par_odd);
                RX_STOP: if (bit_end) begin
                    done <= 1'b1;
                    data <= shreg >> (2'd3 - len_sel);
                    ferr <= !rxs;
                    perr <= perr_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr #(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd
);
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DIV  = 2'd2;

    logic             wr_data, rd_data, wr_ctrl, wr_div;
    logic [1:0]       len_sel, stop_sel;
    logic             par_en, par_odd;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic [7:0]       thr;
    logic             thr_full, take, tx_idle;
    logic [1:0]       rx_sync;
    logic             rx_done, rx_perr, rx_ferr;
    logic [7:0]       rx_data, rbr;
    logic             rx_ready, perr_f, ferr_f, ovr;
    logic [7:0]       status;

    assign wr_data = cs && we  && addr == A_DATA;
    assign rd_data = cs && !we && addr == A_DATA;
    assign wr_ctrl = cs && we  && addr == A_STAT;
    assign wr_div  = cs && we  && addr == A_DIV;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_sel  <= 2'd3;
            par_en   <= 1'b0;
            par_odd  <= 1'b0;
            stop_sel <= 2'd0;
            div_q    <= DIV_W'(DIV_RESET);
        end else begin
            if (wr_ctrl) begin
                len_sel  <= wdata[1:0];
                par_en   <= wdata[2];
                par_odd  <= wdata[3];
                stop_sel <= wdata[5:4];
            end
            if (wr_div) div_q <= wdata[DIV_W-1:0];
        end
    end

    xcvr_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr      <= '0;
            thr_full <= 1'b0;
        end else if (wr_data) begin
            thr      <= wdata;
            thr_full <= 1'b1;
        end else if (take) begin
            thr_full <= 1'b0;
        end
    end

    xcvr_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel),
        .thr_full(thr_full), .thr_data(thr),
        .take(take), .txd(txd), .idle(tx_idle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rxd};
    end

    xcvr_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rx_sync[1]),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbr      <= '0;
            rx_ready <= 1'b0;
            perr_f   <= 1'b0;
            ferr_f   <= 1'b0;
            ovr      <= 1'b0;
        end else if (rx_done) begin
            rbr      <= rx_data;
            rx_ready <= 1'b1;
            perr_f   <= rx_perr;
            ferr_f   <= rx_ferr;
            ovr      <= (ovr || rx_ready) && !rd_data;
        end else if (rd_data) begin
            rx_ready <= 1'b0;
            perr_f   <= 1'b0;
            ferr_f   <= 1'b0;
            ovr      <= 1'b0;
        end
    end

    assign status = {3'b000, ovr, ferr_f, perr_f, rx_ready, !thr_full};

    always_comb begin
        case (addr)
            A_DATA:  rdata = rbr;
            A_STAT:  rdata = status;
            A_DIV:   rdata = 8'(div_q);
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/serial_xcvr_chk.sv
module serial_xcvr_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             we,
    input logic [1:0]       addr,
    input logic             txd,
    input logic             tx_idle,
    input logic             rx_done,
    input logic [7:0]       status,
    input logic             tick,
    input logic [DIV_W-1:0] div_q
);
    p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);

    p_write_clears_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && addr == 2'd0) |=> !status[0]);

    p_read_clears_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && addr == 2'd0 && !rx_done) |=> (status[4:1] == 4'b0000));

    p_overrun_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && status[1] && !(cs && !we && addr == 2'd0)) |=> status[4]);

    p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_q > DIV_W'(1)) |=> !tick);
endmodule

bind serial_xcvr serial_xcvr_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/serial_xcvr_tb.sv
`timescale 1ns/1ps
module serial_xcvr_tb;
    localparam int DIVB = 3;
    localparam int BITC = 16 * DIVB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, we = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int falls[$];
    logic txd_prev = 1'b1;

    serial_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // line monitor: time stamps of every falling edge of the serial output
    always @(negedge clk) begin
        if (txd_prev && !txd) falls.push_back(cyc);
        txd_prev <= txd;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1; we = 0; addr = a;
        #1 d = rdata;
        @(negedge clk); cs = 0;
    endtask

    function automatic int plen(input logic [7:0] c); return 5 + int'(c[1:0]); endfunction

    // transmit one character and check every bit centre
    task automatic tx_frame(input string req, input logic [7:0] ctrl, input logic [7:0] d);
        bit q[$];
        int len = plen(ctrl);
        bit ones = 0;
        int t = 0;
        q.push_back(0);
        for (int i = 0; i < len; i++) begin q.push_back(d[i]); ones ^= d[i]; end
        if (ctrl[2]) q.push_back(ones ^ ctrl[3]);
        q.push_back(1);
        wr(2'd1, ctrl);
        wr(2'd0, d);
        while (txd !== 1'b0 && t < 200) begin @(negedge clk); t++; end
        repeat (BITC / 2) @(negedge clk);
        foreach (q[i]) begin
            chk(req, int'(txd), int'(q[i]));
            repeat (BITC) @(negedge clk);
        end
        repeat (BITC) @(negedge clk);
    endtask

    // two all-zero characters back to back; start-to-start spacing
    task automatic tx_pair(input logic [7:0] ctrl, input int exp);
        logic [7:0] s;
        int t = 0;
        wr(2'd1, ctrl);
        falls.delete();
        wr(2'd0, 8'h00);
        s = 8'h00;
        while (!s[0] && t < 100) begin rd(2'd1, s); t++; end
        wr(2'd0, 8'h00);
        rd(2'd1, s);
        chk("R5 holding-empty clear while full", int'(s[0]), 0);
        repeat (1400) @(negedge clk);
        rd(2'd1, s);
        chk("R5 holding-empty set after take", int'(s[0]), 1);
        chk("R4 falling edge count", falls.size(), 2);
        if (falls.size() >= 2)
            chk("R4 R12 start-to-start spacing", falls[1] - falls[0], exp);
    endtask

    task automatic rx_frame(input logic [7:0] ctrl, input logic [7:0] d,
                            input bit bad_par, input bit bad_stop);
        int len = plen(ctrl);
        bit ones = 0;
        @(negedge clk); rxd = 0; repeat (BITC) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            rxd = d[i]; ones ^= d[i]; repeat (BITC) @(negedge clk);
        end
        if (ctrl[2]) begin
            rxd = ones ^ ctrl[3] ^ bad_par; repeat (BITC) @(negedge clk);
        end
        if (bad_stop) begin
            rxd = 0; repeat (30) @(negedge clk);
            rxd = 1; repeat (BITC - 30) @(negedge clk);
        end else begin
            rxd = 1; repeat (BITC) @(negedge clk);
        end
        repeat (BITC) @(negedge clk);
    endtask

    task automatic rx_case(input string req, input logic [7:0] ctrl, input logic [7:0] d,
                           input bit bad_par, input bit bad_stop, input logic [7:0] exp_st);
        logic [7:0] v;
        wr(2'd1, ctrl);
        rx_frame(ctrl, d, bad_par, bad_stop);
        rd(2'd1, v);
        chk({req, " status"}, v, exp_st);
        rd(2'd0, v);
        chk({req, " data R6"}, v, d & (8'hFF >> (8 - plen(ctrl))));
        rd(2'd1, v);
        chk("R7 status after data read", v, 8'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(2'd1, v);  chk("R1 reset status", v, 8'h01);
        chk("R1 reset line level", int'(txd), 1);
        rd(2'd2, v);  chk("R1 R12 reset divisor", v, 8'd16);
        wr(2'd2, 8'(DIVB));
        rd(2'd2, v);  chk("R12 divisor readback", v, DIVB);

        // transmit framings
        tx_frame("R2 8-bit no parity",        8'h03, 8'hA5);
        tx_frame("R3 5-bit even parity",      8'h04, 8'h13);
        tx_frame("R3 7-bit odd parity",       8'h0E, 8'h55);
        tx_frame("R2 6-bit upper bits unsent", 8'h01, 8'hBF);

        // stop lengths via back-to-back spacing
        tx_pair(8'h03, 9 * BITC + 16 * DIVB);
        tx_pair(8'h13, 9 * BITC + 24 * DIVB);
        tx_pair(8'h23, 9 * BITC + 32 * DIVB);
        tx_pair(8'h1C, 7 * BITC + 24 * DIVB);

        // receive cases
        rx_case("R6 8-bit clean",         8'h03, 8'h3C, 0, 0, 8'h03);
        rx_case("R6 5-bit even good",     8'h04, 8'h15, 0, 0, 8'h03);
        rx_case("R8 7-bit parity flipped", 8'h06, 8'h41, 1, 0, 8'h07);
        rx_case("R9 low stop bit",        8'h03, 8'h81, 0, 1, 8'h0B);

        // overrun
        wr(2'd1, 8'h03);
        rx_frame(8'h03, 8'h11, 0, 0);
        rx_frame(8'h03, 8'h22, 0, 0);
        rd(2'd1, v);  chk("R10 overrun status", v, 8'h13);
        rd(2'd0, v);  chk("R10 newest data kept", v, 8'h22);
        rd(2'd1, v);  chk("R7 overrun cleared by read", v, 8'h01);

        // glitch shorter than half a bit
        @(negedge clk); rxd = 0;
        repeat (12) @(negedge clk);
        rxd = 1;
        repeat (4 * BITC) @(negedge clk);
        rd(2'd1, v);  chk("R11 glitch ignored", v, 8'h01);
        chk("R2 idle line high", int'(txd), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule